// File: doc/BRIEF.md
# Machine Cycle Timing Sequencer

This block turns one bus request into the clock-by-clock pattern of an 8-bit processor bus with a multiplexed low address/data byte. A request names the cycle kind, a 16-bit address, a flag that stretches an opcode fetch, and a flag that marks the last machine cycle of an instruction. The sequencer then walks through its T-states on a single clock. It presents the address and the address latch strobe first. It then runs the read or write strobe, captures or drives the data byte, and pulses a completion flag in the closing state.

The cycle length depends on the kind. A plain fetch takes four states. A stretched fetch takes six, which leaves room for stack pointer work ahead of a stack write. Memory and port reads and writes take three states each. On the last machine cycle of an instruction, an interrupt sampling strobe is raised in the second state. Instruction decode, the register file and wait states belong to the surrounding core.

Top module: `mc_seq`

## Requirements
- R1: A fetch request (kind code 0) with the stretch flag clear lasts four T-states. done_o is high in the fourth state after the accepting edge.
- R2: A fetch request with the stretch flag set lasts six T-states, with done_o high in the sixth.
- R3: Memory read (code 1), memory write (code 2), port read (code 3) and port write (code 4) each last three T-states.
- R4: In T1 only, ale_o is high, ad_o carries address bits 7..0 with ad_oe_o high, and addr_hi_o carries address bits 15..8. addr_hi_o holds that byte for the whole cycle.
- R5: io_m_o is 1 for port cycles (codes 3, 4) and 0 for memory cycles (codes 0, 1, 2), held over the whole cycle. It is 0 when idle.
- R6: rd_no is low in T2 and T3 of codes 0, 1 and 3. wr_no is low in T2 and T3 of codes 2 and 4, with ad_o driving the write byte and ad_oe_o high. ad_oe_o is low in T2 and T3 of read kinds. rd_no and wr_no are never low together.
- R7: For read kinds, rd_data_o takes the value of ad_i at the edge that ends T3.
- R8: int_sample_o is high in T2 of a cycle whose last flag is set, and low at all other times.
- R9: done_o is a single-cycle pulse in the final T-state. A request present in that state starts T1 on the next cycle. Requests made during other busy states are ignored, as are requests with codes 5 to 7.
- R10: While rst_ni is low the sequencer is idle, with ale_o, done_o, int_sample_o and ad_oe_o low and rd_no, wr_no high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one T-state per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 3 | Cycle kind code |
| req_addr_i | input | 16 | Cycle address |
| req_ext_i | input | 1 | Stretch a fetch to six states |
| req_last_i | input | 1 | Last machine cycle of the instruction |
| req_wdata_i | input | 8 | Byte to write |
| ad_i | input | 8 | Multiplexed bus byte in |
| ad_o | output | 8 | Multiplexed bus byte out |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| addr_hi_o | output | 8 | Upper address byte |
| ale_o | output | 1 | Address latch strobe |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | 1 = port cycle, 0 = memory cycle |
| done_o | output | 1 | Final T-state of the cycle |
| int_sample_o | output | 1 | Interrupt sampling strobe |
| rd_data_o | output | 8 | Byte captured by the last read |

## Verification
A wrong state counter or length register shows up within the same machine cycle. ALE lands outside the first state, the read or write strobe covers the wrong states, or done_o arrives one or more states early or late. A bad latched request shows at once as a wrong io_m_o level or a wrong upper address byte. A bad capture shows in rd_data_o on the first clock after T3. The scoreboard compares every output on every cycle, so each such fault is reported in the cycle where it first appears.

// File: rtl/mc_pkg.sv
package mc_pkg;
  parameter int unsigned MC_AW = 16;
  parameter int unsigned MC_DW = 8;

  typedef enum logic [2:0] {
    MC_FETCH = 3'd0,
    MC_MRD   = 3'd1,
    MC_MWR   = 3'd2,
    MC_IORD  = 3'd3,
    MC_IOWR  = 3'd4
  } mc_kind_e;

  typedef struct packed {
    mc_kind_e          kind;
    logic              last;
    logic [MC_AW-1:0]  addr;
    logic [MC_DW-1:0]  wdata;
  } mc_req_t;

  function automatic logic kind_ok(logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic is_io(mc_kind_e k);
    return (k == MC_IORD) || (k == MC_IOWR);
  endfunction

  function automatic logic is_wr(mc_kind_e k);
    return (k == MC_MWR) || (k == MC_IOWR);
  endfunction

  function automatic logic is_rd(mc_kind_e k);
    return (k == MC_FETCH) || (k == MC_MRD) || (k == MC_IORD);
  endfunction
endpackage

// File: rtl/mc_tstate_ctr.sv
module mc_tstate_ctr
  import mc_pkg::*;
#(
  parameter int unsigned FETCH_T = 4,
  parameter int unsigned EXT_T   = 2,
  parameter int unsigned RW_T    = 3,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  mc_kind_e         kind_i,
  input  logic             ext_i,
  output logic [CNT_W-1:0] tstate_o,
  output logic             final_o
);
  localparam logic [CNT_W-1:0] LEN_F  = CNT_W'(FETCH_T);
  localparam logic [CNT_W-1:0] LEN_FX = CNT_W'(FETCH_T + EXT_T);
  localparam logic [CNT_W-1:0] LEN_RW = CNT_W'(RW_T);

  logic [CNT_W-1:0] tstate_q, len_q, len_d;

  always_comb begin
    if (kind_i == MC_FETCH) len_d = ext_i ? LEN_FX : LEN_F;
    else                    len_d = LEN_RW;
  end

  assign final_o  = (tstate_q != '0) && (tstate_q == len_q);
  assign tstate_o = tstate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tstate_q <= '0;
      len_q    <= '0;
    end else if (start_i) begin
      tstate_q <= CNT_W'(1);
      len_q    <= len_d;
    end else if (final_o) begin
      tstate_q <= '0;
    end else if (tstate_q != '0) begin
      tstate_q <= tstate_q + CNT_W'(1);
    end
  end

  // R9: final state lasts one clock
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    final_o |=> !final_o);

  // R9: a busy cycle never skips back to idle early
  a_r9_no_early_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tstate_q != '0 && !final_o) |=> (tstate_q != '0));
endmodule

// File: rtl/mc_strobe_gen.sv
module mc_strobe_gen
  import mc_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned CNT_W = 3
) (
  input  logic [CNT_W-1:0] tstate_i,
  input  logic             final_i,
  input  mc_kind_e         kind_i,
  input  logic             last_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no,
  output logic             io_m_o,
  output logic             done_o,
  output logic             int_sample_o
);
  logic active, t1, t2, data_ph;

  assign active  = (tstate_i != '0);
  assign t1      = (tstate_i == CNT_W'(1));
  assign t2      = (tstate_i == CNT_W'(2));
  assign data_ph = t2 || (tstate_i == CNT_W'(3));

  assign ale_o        = t1;
  assign ad_o         = t1 ? addr_i[DW-1:0] : wdata_i;
  assign ad_oe_o      = t1 || (data_ph && is_wr(kind_i));
  assign addr_hi_o    = active ? addr_i[AW-1:DW] : '0;
  assign io_m_o       = active && is_io(kind_i);
  assign rd_no        = !(data_ph && is_rd(kind_i));
  assign wr_no        = !(data_ph && is_wr(kind_i));
  assign done_o       = final_i;
  assign int_sample_o = t2 && last_i;
endmodule

// File: rtl/mc_seq.sv
module mc_seq
  import mc_pkg::*;
#(
  parameter int unsigned AW      = MC_AW,
  parameter int unsigned DW      = MC_DW,
  parameter int unsigned FETCH_T = 4,
  parameter int unsigned EXT_T   = 2,
  parameter int unsigned RW_T    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [2:0]    req_kind_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_ext_i,
  input  logic          req_last_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic          ale_o,
  output logic          rd_no,
  output logic          wr_no,
  output logic          io_m_o,
  output logic          done_o,
  output logic          int_sample_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned MAX_T = FETCH_T + EXT_T;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] tstate;
  logic             final_t, start;
  mc_kind_e         kind_in;
  mc_req_t          req_q;
  logic [DW-1:0]    rd_data_q;

  assign kind_in = mc_kind_e'(req_kind_i);
  // accept only when idle or in the closing state
  assign start = req_valid_i && kind_ok(req_kind_i) && ((tstate == '0) || final_t);

  mc_tstate_ctr #(
    .FETCH_T(FETCH_T), .EXT_T(EXT_T), .RW_T(RW_T), .CNT_W(CNT_W)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .kind_i   (kind_in),
    .ext_i    (req_ext_i),
    .tstate_o (tstate),
    .final_o  (final_t)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= '0;
      rd_data_q <= '0;
    end else begin
      if (start) begin
        req_q.kind  <= kind_in;
        req_q.last  <= req_last_i;
        req_q.addr  <= req_addr_i;
        req_q.wdata <= req_wdata_i;
      end
      if (tstate == CNT_W'(3) && is_rd(req_q.kind)) rd_data_q <= ad_i;
    end
  end

  assign rd_data_o = rd_data_q;

  mc_strobe_gen #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_strb (
    .tstate_i     (tstate),
    .final_i      (final_t),
    .kind_i       (req_q.kind),
    .last_i       (req_q.last),
    .addr_i       (req_q.addr),
    .wdata_i      (req_q.wdata),
    .ad_o         (ad_o),
    .ad_oe_o      (ad_oe_o),
    .addr_hi_o    (addr_hi_o),
    .ale_o        (ale_o),
    .rd_no        (rd_no),
    .wr_no        (wr_no),
    .io_m_o       (io_m_o),
    .done_o       (done_o),
    .int_sample_o (int_sample_o)
  );

  a_r4_ale_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  a_r6_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  a_r5_iom_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tstate != '0) && !done_o) |=> $stable(io_m_o));

  a_r8_int_after_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sample_o |-> $past(ale_o));

  // R1 / R2: fetch ends four or six states after its ALE
  a_r1_fetch_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && req_q.kind == MC_FETCH) |-> ($past(ale_o, 3) || $past(ale_o, 5)));

  a_r3_rw_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && req_q.kind != MC_FETCH) |-> $past(ale_o, 2));
endmodule

// File: tb/tb_mc_seq.sv
module tb_mc_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [15:0] req_addr = '0;
  logic        req_ext = 1'b0;
  logic        req_last = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  ad_in = '0;
  logic [7:0]  ad_out, addr_hi, rd_data;
  logic        ad_oe, ale, rd_n, wr_n, io_m, done, int_s;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic       ale, rd_n, wr_n, iom, done, intr, oe;
    logic [7:0] ad, hi;
    bit         chk_ad, rd_next;
    logic [7:0] rd_val;
    string      ltag;
  } exp_t;

  exp_t exp_q[$];
  bit        rd_pend = 1'b0;
  logic [7:0] rd_pend_val = '0;

  always #(CLK_P/2) clk = ~clk;

  mc_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_ext_i(req_ext), .req_last_i(req_last),
    .req_wdata_i(req_wdata), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .addr_hi_o(addr_hi), .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n), .io_m_o(io_m),
    .done_o(done), .int_sample_o(int_s), .rd_data_o(rd_data)
  );

  task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cmp_idle(string tag);
    cmp(tag, "ale", 16'(ale), 16'd0);
    cmp(tag, "rd_n", 16'(rd_n), 16'd1);
    cmp(tag, "wr_n", 16'(wr_n), 16'd1);
    cmp(tag, "done", 16'(done), 16'd0);
    cmp(tag, "int", 16'(int_s), 16'd0);
    cmp(tag, "oe", 16'(ad_oe), 16'd0);
    cmp(tag, "io_m", 16'(io_m), 16'd0);
  endtask

  // monitor: sample just before each falling edge
  always @(posedge clk) begin
    #(CLK_P/2 - 1);
    if (!finished) begin
      if (rd_pend) begin
        cmp("R7", "rd_data", 16'(rd_data), 16'(rd_pend_val));
        rd_pend = 1'b0;
      end
      if (!rst_n) cmp_idle("R10");
      else if (exp_q.size() == 0) cmp_idle("R9");
      else begin
        exp_t e;
        e = exp_q.pop_front();
        cmp("R4", "ale", 16'(ale), 16'(e.ale));
        cmp("R6", "rd_n", 16'(rd_n), 16'(e.rd_n));
        cmp("R6", "wr_n", 16'(wr_n), 16'(e.wr_n));
        cmp("R5", "io_m", 16'(io_m), 16'(e.iom));
        cmp(e.ltag, "done", 16'(done), 16'(e.done));
        cmp("R8", "int", 16'(int_s), 16'(e.intr));
        cmp("R6", "oe", 16'(ad_oe), 16'(e.oe));
        cmp("R4", "addr_hi", 16'(addr_hi), 16'(e.hi));
        if (e.chk_ad) cmp(e.ale ? "R4" : "R6", "ad", 16'(ad_out), 16'(e.ad));
        if (e.rd_next) begin
          rd_pend = 1'b1;
          rd_pend_val = e.rd_val;
        end
      end
    end
  end

  // driver: called at a falling edge; returns at the falling edge of the final state
  task automatic issue(logic [2:0] kind, logic [15:0] addr, bit ext, bit last,
                       logic [7:0] wdata, logic [7:0] rdv, bit noise);
    int len;
    bit io, wr, rd;
    string lt;
    io = (kind == 3'd3) || (kind == 3'd4);
    wr = (kind == 3'd2) || (kind == 3'd4);
    rd = !wr;
    if (kind == 3'd0) begin
      len = ext ? 6 : 4;
      lt  = ext ? "R2" : "R1";
    end else begin
      len = 3;
      lt  = "R3";
    end
    for (int t = 1; t <= len; t++) begin
      exp_t e;
      e.ale = (t == 1);
      e.rd_n = !(rd && (t == 2 || t == 3));
      e.wr_n = !(wr && (t == 2 || t == 3));
      e.iom = io;
      e.done = (t == len);
      e.intr = last && (t == 2);
      e.oe = (t == 1) || (wr && (t == 2 || t == 3));
      e.chk_ad = e.oe;
      e.ad = (t == 1) ? addr[7:0] : wdata;
      e.hi = addr[15:8];
      e.rd_next = rd && (t == 3);
      e.rd_val = rdv;
      e.ltag = lt;
      exp_q.push_back(e);
    end
    req_valid = 1'b1;
    req_kind = kind;
    req_addr = addr;
    req_ext = ext;
    req_last = last;
    req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    ad_in = rdv;
    if (noise) begin
      // R9: request during a busy non-final state must be ignored
      req_valid = 1'b1;
      req_kind = 3'd4;
      req_addr = 16'hFFFF;
      req_last = 1'b1;
      req_wdata = 8'hEE;
    end
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic idle(int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    issue(3'd0, 16'h1234, 1'b0, 1'b0, 8'h00, 8'hA5, 1'b0);   // R1
    idle(2);
    issue(3'd0, 16'h8001, 1'b1, 1'b1, 8'h00, 8'h5A, 1'b0);   // R2, R8
    // R9: back to back: fetch then four reads
    issue(3'd0, 16'h4050, 1'b0, 1'b0, 8'h00, 8'h2A, 1'b0);
    issue(3'd1, 16'h4051, 1'b0, 1'b0, 8'h00, 8'h11, 1'b0);
    issue(3'd1, 16'h4052, 1'b0, 1'b0, 8'h00, 8'h22, 1'b0);
    issue(3'd1, 16'h4053, 1'b0, 1'b0, 8'h00, 8'h33, 1'b0);
    issue(3'd1, 16'h4054, 1'b0, 1'b1, 8'h00, 8'h44, 1'b0);
    idle(1);
    issue(3'd2, 16'hC0DE, 1'b0, 1'b0, 8'h3C, 8'h99, 1'b0);   // R3 mem write
    issue(3'd3, 16'h00F7, 1'b0, 1'b0, 8'h00, 8'h77, 1'b0);   // R5 port read
    issue(3'd4, 16'h0021, 1'b0, 1'b1, 8'hC3, 8'h66, 1'b0);   // R5, R6 port write
    idle(2);
    // R9: codes 5..7 not accepted while idle
    req_valid = 1'b1; req_kind = 3'd6; req_addr = 16'hABCD;
    @(negedge clk);
    req_kind = 3'd7;
    @(negedge clk);
    req_valid = 1'b0;
    idle(2);
    issue(3'd1, 16'h9ABC, 1'b0, 1'b0, 8'h00, 8'hB4, 1'b1);   // R9 noise ignored
    issue(3'd0, 16'h7E7E, 1'b1, 1'b0, 8'h00, 8'h0F, 1'b1);   // R2 with noise
    idle(4);
    finished = 1'b1;
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9 queue actual=%0d expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule